// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register Block

This block holds the programmable state of an interrupt router: an identifier register, a read-only version register, an arbitration register that mirrors the identifier, and a table of redirection entries. Each entry is 64 bits wide and has one entry per interrupt pin. Software does not address the registers directly. It first writes a register index into a select register and then reads or writes a 32-bit data window. Each table entry appears as two window indices, one for the low word and one for the high word.

The whole table is driven out every cycle so that a separate delivery engine can read the vector, mode, destination and mask of every pin. That engine owns the remote-IRR status bit of each entry and sets or clears it through a dedicated side port. Software cannot change that bit. After each table write the block reports which pin was written, so that the engine can decide whether to redeliver. It also raises a one-cycle recompute strobe when the write changed anything that affects trigger-mode bookkeeping.

Top module: `irq_redir_regs`

## Requirements
- R1: An access takes effect only when it is 4 bytes wide (size code 4) and addressed to byte offset 0x00 (select) or 0x10 (window). Any other access returns 0 on a read and changes nothing on a write.
- R2: A read of the select register returns the full 32-bit value last written to it. Window accesses use only bits 7:0 of that value as the register index.
- R3: A window write to index 0x00 stores only data bits 27:24 into the identifier register and clears its other bits. Indices 0x00 and 0x02 both read back the stored identifier.
- R4: Index 0x01 reads ((NUM_PINS-1) << 16) | 0x11, which is 0x00170011 for 24 pins. Window writes to indices 0x01 and 0x02 change nothing.
- R5: Entry n is reached at index 0x10+2n for bits 31:0 and at index 0x11+2n for bits 63:32. The table output carries entry n on bits 64n+63 down to 64n.
- R6: A table write keeps the current values of bit 12 (delivery status) and bit 14 (remote IRR) and replaces every other bit of the addressed 32-bit half.
- R7: After reset every entry equals 0x0001000000010000 (mask bit 16 set), and the identifier and select registers are 0.
- R8: One cycle after a table write, the recompute strobe is high for one cycle if any entry bit other than bit 13 (polarity) or bit 16 (mask) changed. Otherwise it stays low.
- R9: Window reads of indices 0x03 to 0x0F and of 0x10+2*NUM_PINS to 0xFF return 0, and window writes to them change nothing.
- R10: A side-port set or clear of the remote IRR bit of a pin shows in the table output one cycle later. If both act on the same pin in the same cycle, the set wins.
- R11: One cycle after every table write, whether or not it changed anything, the write-event output is high for one cycle and carries the pin number.
- R12: Read data and the read-valid flag appear exactly one cycle after a read request, and the read-valid flag is high only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| bus_rvalid | output | 1 | Read data valid |
| rirr_set_valid | input | 1 | Set remote IRR of rirr_set_pin |
| rirr_set_pin | input | 5 | Pin whose remote IRR is set |
| rirr_clr_valid | input | 1 | Clear remote IRR of rirr_clr_pin |
| rirr_clr_pin | input | 5 | Pin whose remote IRR is cleared |
| tbl_flat | output | 1536 | All entries, entry n at bits 64n+63:64n |
| tmr_recompute | output | 1 | One-cycle strobe: trigger-relevant bits changed |
| wr_evt_valid | output | 1 | One-cycle strobe: a table entry was written |
| wr_evt_pin | output | 5 | Pin of the written entry |

## Verification
The bench reads every one of the 256 window indices and compares each with a bench-side model. It writes both halves of every entry with patterns that set the protected bits. A design that swapped the even and odd halves, or that let software overwrite remote IRR, would return the wrong word or lose a bit the engine had set. The strobe cases cover a change to the mask alone, a change to the polarity alone, an identical rewrite and a vector change. A design that compared the wrong bits would either miss a recompute or raise false ones, while the write event must still fire for every write. Narrow accesses, stray offsets, writes to the read-only registers and writes to undefined indices are each followed by a full table and register check, so a decoder that let any of them through shows up as a changed state.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0]  OFF_SELECT = 8'h00;
  localparam logic [7:0]  OFF_WINDOW = 8'h10;
  localparam logic [2:0]  ACC_WORD   = 3'd4;

  localparam logic [7:0]  IDX_ID  = 8'h00;
  localparam logic [7:0]  IDX_VER = 8'h01;
  localparam logic [7:0]  IDX_ARB = 8'h02;
  localparam logic [7:0]  IDX_TBL = 8'h10;

  localparam logic [31:0] ID_FIELD   = 32'h0F00_0000;
  localparam logic [31:0] VER_CODE   = 32'h0000_0011;
  localparam int          MAXRED_LSB = 16;

  // protected bits: delivery status (12), remote IRR (14)
  localparam int          B_RIRR   = 14;
  localparam logic [31:0] RO_LO    = 32'h0000_5000;
  localparam logic [31:0] RO_HI    = 32'h0000_0000;
  // bits whose change does not call for a recompute: polarity (13), mask (16)
  localparam logic [31:0] NOTRIG_LO = 32'h0001_2000;

  localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ID,
    REG_VER,
    REG_ARB,
    REG_TBL
  } reg_kind_t;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [7:0]       bus_offset,
  input  logic [2:0]       bus_size,
  input  logic [7:0]       sel_idx,
  output logic             sel_we,
  output logic             win_we,
  output logic             sel_re,
  output logic             win_re,
  output logic             any_re,
  output reg_kind_t        kind,
  output logic [PIN_W-1:0] pin,
  output logic             hi
);
  localparam int TBL_END = 16 + 2 * NUM_PINS;

  logic       word_ok;
  logic [7:0] rel;
  logic [6:0] half_idx;

  always_comb begin
    word_ok  = bus_valid && (bus_size == ACC_WORD);
    sel_we   = word_ok && bus_write  && (bus_offset == OFF_SELECT);
    win_we   = word_ok && bus_write  && (bus_offset == OFF_WINDOW);
    sel_re   = word_ok && !bus_write && (bus_offset == OFF_SELECT);
    win_re   = word_ok && !bus_write && (bus_offset == OFF_WINDOW);
    any_re   = bus_valid && !bus_write;
    rel      = sel_idx - IDX_TBL;
    half_idx = rel[7:1];
    pin      = half_idx[PIN_W-1:0];
    hi       = rel[0];
    if (sel_idx == IDX_ID)       kind = REG_ID;
    else if (sel_idx == IDX_VER) kind = REG_VER;
    else if (sel_idx == IDX_ARB) kind = REG_ARB;
    else if ((sel_idx >= IDX_TBL) && (32'(sel_idx) < TBL_END)) kind = REG_TBL;
    else                         kind = REG_NONE;
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PIN_W-1:0]       wr_pin,
  input  logic                   wr_hi,
  input  logic [31:0]            wr_data,
  input  logic [PIN_W-1:0]       rd_pin,
  input  logic                   rd_hi,
  output logic [31:0]            rd_word,
  input  logic                   set_valid,
  input  logic [PIN_W-1:0]       set_pin,
  input  logic                   clr_valid,
  input  logic [PIN_W-1:0]       clr_pin,
  output logic                   trig_change,
  output logic [NUM_PINS*64-1:0] entries
);
  logic [63:0] ent [NUM_PINS];
  logic [63:0] wr_old;
  logic [31:0] old_half, new_half, ro_mask, care_mask;

  always_comb begin
    wr_old    = ent[wr_pin];
    ro_mask   = wr_hi ? RO_HI : RO_LO;
    care_mask = wr_hi ? 32'hFFFF_FFFF : ~NOTRIG_LO;
    old_half  = wr_hi ? wr_old[63:32] : wr_old[31:0];
    new_half  = (wr_data & ~ro_mask) | (old_half & ro_mask);
    trig_change = |((old_half ^ new_half) & care_mask);
  end

  always_comb begin
    rd_word = rd_hi ? ent[rd_pin][63:32] : ent[rd_pin][31:0];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic hit_wr, hit_set, hit_clr;
    always_comb begin
      hit_wr  = wr_en && (wr_pin == PIN_W'(i));
      hit_set = set_valid && (set_pin == PIN_W'(i));
      hit_clr = clr_valid && (clr_pin == PIN_W'(i));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ent[i] <= ENTRY_RST;
      end else begin
        if (hit_wr) begin
          if (wr_hi) ent[i][63:32] <= new_half;
          else       ent[i][31:0]  <= new_half;
        end
        if (hit_set)      ent[i][B_RIRR] <= 1'b1;
        else if (hit_clr) ent[i][B_RIRR] <= 1'b0;
      end
    end

    assign entries[i*64 +: 64] = ent[i];
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [7:0]             bus_offset,
  input  logic [2:0]             bus_size,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  input  logic                   rirr_set_valid,
  input  logic [PIN_W-1:0]       rirr_set_pin,
  input  logic                   rirr_clr_valid,
  input  logic [PIN_W-1:0]       rirr_clr_pin,
  output logic [NUM_PINS*64-1:0] tbl_flat,
  output logic                   tmr_recompute,
  output logic                   wr_evt_valid,
  output logic [PIN_W-1:0]       wr_evt_pin
);
  localparam logic [31:0] VER_WORD = (32'(NUM_PINS - 1) << MAXRED_LSB) | VER_CODE;

  logic [31:0]      sel_q;
  logic [31:0]      id_q;
  logic             sel_we, win_we, sel_re, win_re, any_re;
  reg_kind_t        kind;
  logic [PIN_W-1:0] pin;
  logic             hi;
  logic             tbl_we;
  logic [31:0]      tbl_word;
  logic             trig_change;
  logic [31:0]      rd_next;

  irq_redir_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_offset(bus_offset),
    .bus_size  (bus_size),
    .sel_idx   (sel_q[7:0]),
    .sel_we    (sel_we),
    .win_we    (win_we),
    .sel_re    (sel_re),
    .win_re    (win_re),
    .any_re    (any_re),
    .kind      (kind),
    .pin       (pin),
    .hi        (hi)
  );

  assign tbl_we = win_we && (kind == REG_TBL);

  irq_redir_table #(.NUM_PINS(NUM_PINS)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (tbl_we),
    .wr_pin     (pin),
    .wr_hi      (hi),
    .wr_data    (bus_wdata),
    .rd_pin     (pin),
    .rd_hi      (hi),
    .rd_word    (tbl_word),
    .set_valid  (rirr_set_valid),
    .set_pin    (rirr_set_pin),
    .clr_valid  (rirr_clr_valid),
    .clr_pin    (rirr_clr_pin),
    .trig_change(trig_change),
    .entries    (tbl_flat)
  );

  always_comb begin
    rd_next = '0;
    if (sel_re) begin
      rd_next = sel_q;
    end else if (win_re) begin
      case (kind)
        REG_ID, REG_ARB: rd_next = id_q;
        REG_VER:         rd_next = VER_WORD;
        REG_TBL:         rd_next = tbl_word;
        default:         rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q         <= '0;
      id_q          <= '0;
      bus_rdata     <= '0;
      bus_rvalid    <= 1'b0;
      tmr_recompute <= 1'b0;
      wr_evt_valid  <= 1'b0;
      wr_evt_pin    <= '0;
    end else begin
      if (sel_we) sel_q <= bus_wdata;
      if (win_we && (kind == REG_ID)) id_q <= bus_wdata & ID_FIELD;
      bus_rvalid    <= any_re;
      bus_rdata     <= any_re ? rd_next : '0;
      tmr_recompute <= tbl_we && trig_change;
      wr_evt_valid  <= tbl_we;
      if (tbl_we) wr_evt_pin <= pin;
    end
  end
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [7:0]             bus_offset,
  input logic [2:0]             bus_size,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvalid,
  input logic                   rirr_set_valid,
  input logic [PIN_W-1:0]       rirr_set_pin,
  input logic                   rirr_clr_valid,
  input logic [NUM_PINS*64-1:0] tbl_flat,
  input logic                   tmr_recompute,
  input logic                   wr_evt_valid
);
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid == $past(bus_valid && !bus_write)); // R12

  AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && ($past(bus_size) != 3'd4)) |-> (bus_rdata == 32'd0)); // R1

  AST_STRAY_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && ($past(bus_offset) != 8'h00) && ($past(bus_offset) != 8'h10))
      |-> (bus_rdata == 32'd0)); // R1

  AST_RECOMP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    tmr_recompute |-> wr_evt_valid); // R8

  AST_EVT_FROM_WINDOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_evt_valid |-> $past(bus_valid && bus_write && bus_offset == 8'h10 && bus_size == 3'd4)); // R11

  AST_RIRR_SET_SEEN: assert property (@(posedge clk) disable iff (rst)
    rirr_set_valid |=> tbl_flat[$past(rirr_set_pin) * 64 + 14]); // R10

  AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid && !rirr_set_valid && !rirr_clr_valid) |=> $stable(tbl_flat)); // R5
endmodule

bind irq_redir_regs irq_redir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_offset    (bus_offset),
  .bus_size      (bus_size),
  .bus_rdata     (bus_rdata),
  .bus_rvalid    (bus_rvalid),
  .rirr_set_valid(rirr_set_valid),
  .rirr_set_pin  (rirr_set_pin),
  .rirr_clr_valid(rirr_clr_valid),
  .tbl_flat      (tbl_flat),
  .tmr_recompute (tmr_recompute),
  .wr_evt_valid  (wr_evt_valid)
);

// File: tb/test_irq_redir_regs.sv
module test_irq_redir_regs;
  localparam int NP = 24;
  localparam int PW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]      bus_offset = '0;
  logic [2:0]      bus_size = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic            rirr_set_valid = 1'b0, rirr_clr_valid = 1'b0;
  logic [PW-1:0]   rirr_set_pin = '0, rirr_clr_pin = '0;
  logic [NP*64-1:0] tbl_flat;
  logic            tmr_recompute, wr_evt_valid;
  logic [PW-1:0]   wr_evt_pin;

  int n_tests = 0, n_fail = 0;
  logic [63:0] m_tbl [NP];
  logic [31:0] m_id;
  logic [31:0] m_sel;
  logic [31:0] got_rd;
  logic        got_rv, got_rc, got_ev;
  logic [PW-1:0] got_pin;

  irq_redir_regs #(.NUM_PINS(NP)) i_irq_redir_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_offset(bus_offset), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rirr_set_valid(rirr_set_valid), .rirr_set_pin(rirr_set_pin),
    .rirr_clr_valid(rirr_clr_valid), .rirr_clr_pin(rirr_clr_pin),
    .tbl_flat(tbl_flat), .tmr_recompute(tmr_recompute),
    .wr_evt_valid(wr_evt_valid), .wr_evt_pin(wr_evt_pin));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_offset = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    got_rd = bus_rdata; got_rv = bus_rvalid; got_rc = tmr_recompute;
    got_ev = wr_evt_valid; got_pin = wr_evt_pin;
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] idx);
    if (idx == 8'h00 || idx == 8'h02) return m_id;
    if (idx == 8'h01) return 32'h0017_0011;
    if (idx >= 8'h10 && int'(idx) < 16 + 2 * NP)
      return idx[0] ? m_tbl[(idx - 8'h10) >> 1][63:32] : m_tbl[(idx - 8'h10) >> 1][31:0];
    return 32'h0;
  endfunction

  task automatic win_read(input logic [7:0] idx, input string req);
    access(1'b1, 8'h00, 3'd4, {24'h0, idx});
    m_sel = {24'h0, idx};
    access(1'b0, 8'h10, 3'd4, 32'h0);
    chk({req, " rvalid R12"}, 64'(got_rv), 64'd1);
    chk(req, 64'(got_rd), 64'(exp_read(idx)));
  endtask

  // table write through the window with the bench model and strobe checks
  task automatic tbl_write(input int p, input logic h, input logic [31:0] d);
    logic [31:0] oldh, newh, ro, care;
    logic exp_rc;
    oldh = h ? m_tbl[p][63:32] : m_tbl[p][31:0];
    ro   = h ? 32'h0 : 32'h0000_5000;
    care = h ? 32'hFFFF_FFFF : ~32'h0001_2000;
    newh = (d & ~ro) | (oldh & ro);
    exp_rc = |((oldh ^ newh) & care);
    if (h) m_tbl[p][63:32] = newh; else m_tbl[p][31:0] = newh;
    access(1'b1, 8'h00, 3'd4, 32'h10 + 32'(2 * p) + 32'(h));
    m_sel = 32'h10 + 32'(2 * p) + 32'(h);
    access(1'b1, 8'h10, 3'd4, d);
    chk("R8 recompute", 64'(got_rc), 64'(exp_rc));
    chk("R11 event valid", 64'(got_ev), 64'd1);
    chk("R11 event pin", 64'(got_pin), 64'(p));
  endtask

  task automatic chk_table(input string req);
    for (int i = 0; i < NP; i++) chk(req, tbl_flat[i*64 +: 64], m_tbl[i]);
  endtask

  task automatic rirr(input logic s, input logic c, input int ps, input int pc);
    @(negedge clk);
    rirr_set_valid = s; rirr_set_pin = PW'(ps);
    rirr_clr_valid = c; rirr_clr_pin = PW'(pc);
    @(negedge clk);
    rirr_set_valid = 1'b0; rirr_clr_valid = 1'b0;
    if (c) m_tbl[pc][14] = 1'b0;
    if (s) m_tbl[ps][14] = 1'b1;
  endtask

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired R12 actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0001_0000_0001_0000;
    m_id = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk_table("R7 reset entry");
    chk("R12 rvalid idle", 64'(bus_rvalid), 64'd0);
    chk("R8 no strobe at reset", 64'(tmr_recompute), 64'd0);
    access(1'b0, 8'h00, 3'd4, 32'h0);
    chk("R7 select reset", 64'(got_rd), 64'd0);

    // full index sweep: R3 R4 R5 R9 and select readback R2
    for (int k = 0; k < 256; k++) begin
      win_read(8'(k), "R9 sweep");
      access(1'b0, 8'h00, 3'd4, 32'h0);
      chk("R2 select readback", 64'(got_rd), 64'(m_sel));
    end

    // R2 upper select bits ignored for indexing
    access(1'b1, 8'h00, 3'd4, 32'h1234_5601);
    access(1'b0, 8'h00, 3'd4, 32'h0);
    chk("R2 select full word", 64'(got_rd), 64'h1234_5601);
    access(1'b0, 8'h10, 3'd4, 32'h0);
    chk("R2 index low byte", 64'(got_rd), 64'h0017_0011);

    // R3 identifier field
    access(1'b1, 8'h00, 3'd4, 32'h0);
    access(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
    m_id = 32'h0F00_0000;
    win_read(8'h00, "R3 id");
    win_read(8'h02, "R3 arb mirror");
    // R4 read-only registers
    access(1'b1, 8'h00, 3'd4, 32'h1);
    access(1'b1, 8'h10, 3'd4, 32'h0);
    access(1'b1, 8'h00, 3'd4, 32'h2);
    access(1'b1, 8'h10, 3'd4, 32'h0);
    win_read(8'h01, "R4 version");
    win_read(8'h02, "R4 arb unchanged");
    win_read(8'h00, "R4 id unchanged");

    // R5 R6 every entry, both halves
    for (int p = 0; p < NP; p++) begin
      tbl_write(p, 1'b0, 32'hFFFF_FFFF ^ (32'(p) << 3));
      tbl_write(p, 1'b1, 32'h5A00_0000 ^ (32'(p) * 32'h0101_0101));
    end
    chk_table("R6 protected bits");
    for (int k = 16; k < 16 + 2 * NP; k++) win_read(8'(k), "R5 readback");

    // R8 strobe selectivity on pin 7
    tbl_write(7, 1'b0, 32'h0000_8031);
    tbl_write(7, 1'b0, 32'h0001_8031);   // mask only
    tbl_write(7, 1'b0, 32'h0001_A031);   // polarity only
    tbl_write(7, 1'b0, 32'h0001_A031);   // identical
    tbl_write(7, 1'b0, 32'h0001_A032);   // vector
    tbl_write(7, 1'b1, 32'h0100_0000);
    tbl_write(7, 1'b1, 32'h0100_0000);
    chk_table("R8 table after strobes");

    // R10 side port and R6 protection of remote IRR
    rirr(1'b1, 1'b0, 3, 0);
    chk("R10 set", 64'(tbl_flat[3*64 + 14]), 64'd1);
    tbl_write(3, 1'b0, 32'h0);
    chk("R6 rirr kept", 64'(tbl_flat[3*64 + 14]), 64'd1);
    win_read(8'h16, "R6 rirr readback");
    rirr(1'b0, 1'b1, 0, 3);
    chk("R10 clear", 64'(tbl_flat[3*64 + 14]), 64'd0);
    rirr(1'b1, 1'b1, 9, 9);
    chk("R10 set wins", 64'(tbl_flat[9*64 + 14]), 64'd1);
    rirr(1'b1, 1'b1, 23, 9);
    chk_table("R10 two pins");

    // R1 stray accesses and R9 undefined indices
    access(1'b1, 8'h00, 3'd4, 32'h10);
    m_sel = 32'h10;
    access(1'b1, 8'h10, 3'd2, 32'hDEAD_BEEF);
    access(1'b1, 8'h00, 3'd1, 32'h01);
    access(1'b1, 8'h04, 3'd4, 32'h02);
    access(1'b1, 8'h14, 3'd4, 32'hCAFE_F00D);
    chk("R1 no event", 64'(got_ev), 64'd0);
    access(1'b0, 8'h10, 3'd2, 32'h0);
    chk("R1 narrow read zero", 64'(got_rd), 64'd0);
    chk("R1 narrow read valid R12", 64'(got_rv), 64'd1);
    access(1'b0, 8'h08, 3'd4, 32'h0);
    chk("R1 stray read zero", 64'(got_rd), 64'd0);
    access(1'b0, 8'h00, 3'd4, 32'h0);
    chk("R1 select unchanged", 64'(got_rd), 64'h10);
    access(1'b1, 8'h00, 3'd4, 32'h05);
    access(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
    access(1'b1, 8'h00, 3'd4, 32'h40);
    access(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
    chk("R9 no event", 64'(got_ev), 64'd0);
    chk_table("R1 R9 table untouched");
    win_read(8'h00, "R9 id untouched");
    win_read(8'h05, "R9 undefined read");
    win_read(8'h40, "R9 past table");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule